// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Hardware Address Filter

This block receives asynchronous serial frames of eight or nine data bits from an oversampled line and decides, in hardware, whether each frame is handed on. A free-running receive line is brought into the clock domain through a synchronizer. A frame engine confirms the start bit, votes each data bit from three samples taken around the centre of the bit, and checks the stop bit. A comparator matches the received byte against a node address and a mask.

In multi-drop systems the filter lets a node ignore traffic addressed to other nodes without software involvement. The "given" address is formed from the node address and the mask. Bits where the mask is 0 are don't-care. The "broadcast" address is the node address ORed with the mask, and bits that are 0 in that value are don't-care. A zero mask together with a zero node address makes every byte match, so filtering is effectively off after reset. The receive-done flag rises only for frames that pass. A missing stop bit raises a framing flag that stays set until software clears it.

Top module: `addr_filter_uart_rx`

## Requirements
- R1: After reset, `rx_done`, `frame_err`, `rx_byte` and `rx_bit9` are all 0.
- R2: A falling line edge starts a frame only if the vote of the three middle samples of that bit (samples 7, 8 and 9 of 16) is low. A shorter low pulse is a false start and produces no frame and no flag.
- R3: Data bits arrive LSB first. Each bit is the 2-of-3 majority of samples 7, 8 and 9, so one corrupted sample inside that window does not change the received value.
- R4: `frame_mode` encoding: 2'b00 is plain-byte mode (eight data bits), 2'b01 is 8-bit mode, and 2'b10 and 2'b11 are 9-bit modes. On an accepted frame, `rx_bit9` takes the ninth data bit in the 9-bit modes and the stop-bit value in the other modes.
- R5: In plain-byte mode every frame is accepted, whatever `mp_en` and the stop bit are.
- R6: In 8-bit mode, a frame is accepted when its stop bit is 1 and either `mp_en` is 0 or the byte hits the given or broadcast address.
- R7: In the 9-bit modes with `mp_en` = 0, a frame is accepted when its stop bit is 1. With `mp_en` = 1, a frame is accepted only when the ninth bit is 1 and the byte hits the given or broadcast address.
- R8: Given-address hit: at every bit position where `addr_mask` is 1, the byte equals `node_addr`.
- R9: Broadcast hit: at every bit position where (`node_addr` | `addr_mask`) is 1, the byte is 1.
- R10: With `node_addr` and `addr_mask` both zero, every byte is a hit.
- R11: In any mode, a stop bit voted 0 sets `frame_err`. The flag stays set until `flag_clr`.
- R12: `rx_byte` and `rx_bit9` are loaded only by an accepted frame. A rejected frame leaves them and `rx_done` unchanged.
- R13: `flag_clr` clears `rx_done` and `frame_err` on the next edge. If a frame completes in the same cycle, the flags it sets take precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_tick | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Asynchronous receive line, idle high |
| frame_mode | input | 2 | Frame format select (see R4) |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| node_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address mask; a 0 bit is don't-care |
| flag_clr | input | 1 | Clears `rx_done` and `frame_err` |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the last accepted frame |
| rx_done | output | 1 | Sticky flag: an accepted frame is available |
| frame_err | output | 1 | Sticky flag: a stop bit was missing |

## Verification
The bench uses the default parameters: 16 samples per bit, 8 data bits and a two-stage synchronizer. It pulses `sample_tick` on every second clock, so each bit lasts 32 clocks and the tick gating in the frame engine is exercised. With these values, a single-sample glitch lands inside the three-sample voting window, and a short low pulse falls back before mid-bit, so R2 and R3 can be reached directly. Random frames span all four modes, zero and non-zero masks, and bytes built to hit the given or broadcast address, with occasional bad stop bits.

// File: rtl/uart_af_pkg.sv
// Shared types and helpers for the address-filtering serial receiver.
// Assumes frame_mode is held stable while a frame is on the line.
package uart_af_pkg;

    localparam logic [1:0] MODE_PLAIN = 2'b00;
    localparam logic [1:0] MODE_8BIT  = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    // 2-of-3 majority of the samples around mid-bit.
    function automatic logic vote3(input logic [2:0] s);
        return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
    endfunction

endpackage

// File: rtl/uart_af_sync.sv
// Multi-stage synchronizer for the asynchronous receive line.
// Assumes STAGES >= 2. Resets to the idle (high) level.
module uart_af_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_af_framer.sv
// Frame engine: start-bit qualification, majority-voted data bits and
// stop-bit capture. Advances only on sample_tick. Assumes OVERSAMPLE >= 4.
// frame_end pulses for one clock with the frame fields valid alongside it.
module uart_af_framer
    import uart_af_pkg::*;
#(
    parameter int OVERSAMPLE = 16,
    parameter int DATA_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              nine_bit,
    output logic              frame_end,
    output logic [DATA_W-1:0] frame_data,
    output logic              extra_bit,
    output logic              stop_ok
);
    localparam int CNT_W  = $clog2(OVERSAMPLE);
    localparam int IDX_W  = $clog2(DATA_W + 1);
    localparam int MID    = OVERSAMPLE / 2;
    localparam logic [CNT_W-1:0] S_LO   = CNT_W'(MID - 1);
    localparam logic [CNT_W-1:0] S_MID  = CNT_W'(MID);
    localparam logic [CNT_W-1:0] S_HI   = CNT_W'(MID + 1);
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(OVERSAMPLE - 1);

    rx_state_e          state;
    logic [CNT_W-1:0]   tick_cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [1:0]         early;
    logic [DATA_W:0]    shreg;
    logic               nine_q;
    logic               stop_q;
    logic               vote;
    logic [IDX_W-1:0]   last_idx;

    assign vote     = vote3({rxd_s, early});
    assign last_idx = nine_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

    // Sequence the frame one sample tick at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tick_cnt  <= '0;
            bit_idx   <= '0;
            early     <= '0;
            shreg     <= '0;
            nine_q    <= 1'b0;
            stop_q    <= 1'b0;
            frame_end <= 1'b0;
        end else begin
            frame_end <= 1'b0;
            if (tick) begin
                if (state != ST_IDLE) begin
                    tick_cnt <= (tick_cnt == S_LAST) ? '0 : tick_cnt + 1'b1;
                    if (tick_cnt == S_LO)  early[0] <= rxd_s;
                    if (tick_cnt == S_MID) early[1] <= rxd_s;
                end
                unique case (state)
                    ST_IDLE: begin
                        if (!rxd_s) begin
                            state    <= ST_START;
                            tick_cnt <= CNT_W'(1);
                            nine_q   <= nine_bit;
                            shreg    <= '0;
                        end
                    end
                    ST_START: begin
                        if (tick_cnt == S_HI && vote) begin
                            state <= ST_IDLE;
                        end else if (tick_cnt == S_LAST) begin
                            state   <= ST_DATA;
                            bit_idx <= '0;
                        end
                    end
                    ST_DATA: begin
                        if (tick_cnt == S_HI) shreg[bit_idx] <= vote;
                        if (tick_cnt == S_LAST) begin
                            if (bit_idx == last_idx) state <= ST_STOP;
                            else                     bit_idx <= bit_idx + 1'b1;
                        end
                    end
                    ST_STOP: begin
                        if (tick_cnt == S_HI) begin
                            stop_q    <= vote;
                            frame_end <= 1'b1;
                            state     <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign frame_data = shreg[DATA_W-1:0];
    assign extra_bit  = nine_q ? shreg[DATA_W] : stop_q;
    assign stop_ok    = stop_q;
endmodule

// File: rtl/uart_af_match.sv
// Masked address comparator: flags a given-address hit and a broadcast
// hit. Purely combinational.
module uart_af_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] rx_data,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] addr_mask,
    output logic              given_hit,
    output logic              bcast_hit,
    output logic              addr_hit
);
    logic [DATA_W-1:0] bcast_addr;

    // Compare only the bit positions each address cares about.
    always_comb begin
        bcast_addr = node_addr | addr_mask;
        given_hit  = ((rx_data ^ node_addr) & addr_mask) == '0;
        bcast_hit  = (bcast_addr & ~rx_data) == '0;
        addr_hit   = given_hit | bcast_hit;
    end
endmodule

// File: rtl/addr_filter_uart_rx.sv
// Top level: serial receiver whose done flag is gated by a hardware
// address filter. Assumes frame_mode, mp_en and the address inputs are
// stable while a frame is received.
module addr_filter_uart_rx
    import uart_af_pkg::*;
#(
    parameter int OVERSAMPLE  = 16,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_tick,
    input  logic              rxd,
    input  logic [1:0]        frame_mode,
    input  logic              mp_en,
    input  logic [DATA_W-1:0] node_addr,
    input  logic [DATA_W-1:0] addr_mask,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_done,
    output logic              frame_err
);
    logic              rxd_s;
    logic              frame_end;
    logic [DATA_W-1:0] frame_data;
    logic              extra_bit;
    logic              stop_ok;
    logic              given_hit;
    logic              bcast_hit;
    logic              addr_hit;
    logic              accept;

    uart_af_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rxd_s)
    );

    uart_af_framer #(.OVERSAMPLE(OVERSAMPLE), .DATA_W(DATA_W)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (sample_tick),
        .rxd_s      (rxd_s),
        .nine_bit   (frame_mode[1]),
        .frame_end  (frame_end),
        .frame_data (frame_data),
        .extra_bit  (extra_bit),
        .stop_ok    (stop_ok)
    );

    uart_af_match #(.DATA_W(DATA_W)) u_match (
        .rx_data   (frame_data),
        .node_addr (node_addr),
        .addr_mask (addr_mask),
        .given_hit (given_hit),
        .bcast_hit (bcast_hit),
        .addr_hit  (addr_hit)
    );

    // Decide whether the completed frame is handed on.
    always_comb begin
        if (frame_mode == MODE_PLAIN)      accept = 1'b1;
        else if (frame_mode == MODE_8BIT)  accept = stop_ok & (~mp_en | addr_hit);
        else if (mp_en)                    accept = extra_bit & addr_hit;
        else                               accept = stop_ok;
    end

    // Hold the result registers and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte   <= '0;
            rx_bit9   <= 1'b0;
            rx_done   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            if (flag_clr) begin
                rx_done   <= 1'b0;
                frame_err <= 1'b0;
            end
            if (frame_end && accept) begin
                rx_byte <= frame_data;
                rx_bit9 <= extra_bit;
                rx_done <= 1'b1;
            end
            if (frame_end && !stop_ok) frame_err <= 1'b1;
        end
    end
endmodule

// File: rtl/addr_filter_uart_rx_chk.sv
// Checker for addr_filter_uart_rx, attached with bind. Relates the frame
// completion strobe from the frame engine to the flag and data outputs.
module addr_filter_uart_rx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        frame_mode,
    input logic              mp_en,
    input logic [DATA_W-1:0] node_addr,
    input logic [DATA_W-1:0] addr_mask,
    input logic              flag_clr,
    input logic              frame_end,
    input logic              stop_ok,
    input logic [DATA_W-1:0] rx_byte,
    input logic              rx_bit9,
    input logic              rx_done,
    input logic              frame_err
);
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done && !flag_clr |=> rx_done); // R13
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !frame_end |=> !rx_done && !frame_err); // R13
    AST_FERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err && !flag_clr |=> frame_err); // R11
    AST_FERR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(frame_end && !stop_ok)); // R11
    AST_BYTE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> rx_done); // R12
    AST_PLAIN_TAKES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && frame_mode == 2'b00 |=> rx_done); // R5
    AST_MP9_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) && $past(frame_mode[1] && mp_en) |-> rx_bit9); // R7
    AST_ZERO_FILTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end && stop_ok && !frame_mode[1] && addr_mask == '0 && node_addr == '0
        |=> rx_done); // R10
endmodule

bind addr_filter_uart_rx addr_filter_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_mode (frame_mode),
    .mp_en      (mp_en),
    .node_addr  (node_addr),
    .addr_mask  (addr_mask),
    .flag_clr   (flag_clr),
    .frame_end  (frame_end),
    .stop_ok    (stop_ok),
    .rx_byte    (rx_byte),
    .rx_bit9    (rx_bit9),
    .rx_done    (rx_done),
    .frame_err  (frame_err)
);

// File: tb/addr_filter_uart_rx_tb.sv
module addr_filter_uart_rx_tb;
    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;
    localparam int BIT_CLKS   = OVS * 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [1:0] frame_mode = 2'b00;
    logic       mp_en = 1'b0;
    logic [7:0] node_addr = 8'h00;
    logic [7:0] addr_mask = 8'h00;
    logic       flag_clr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       rx_done;
    logic       frame_err;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [7:0] prev_byte = 8'h00;
    logic       prev_b9   = 1'b0;

    addr_filter_uart_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sample_tick (sample_tick),
        .rxd         (rxd),
        .frame_mode  (frame_mode),
        .mp_en       (mp_en),
        .node_addr   (node_addr),
        .addr_mask   (addr_mask),
        .flag_clr    (flag_clr),
        .rx_byte     (rx_byte),
        .rx_bit9     (rx_bit9),
        .rx_done     (rx_done),
        .frame_err   (frame_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            sample_tick = ~sample_tick;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit addr_hit(input logic [7:0] b, input logic [7:0] na,
                                    input logic [7:0] m);
        logic [7:0] bc;
        bc = na | m;
        return (((b ^ na) & m) == 8'h00) || ((bc & ~b) == 8'h00);
    endfunction

    function automatic bit exp_accept(input logic [1:0] md, input logic mp,
                                      input logic [7:0] na, input logic [7:0] m,
                                      input logic [7:0] b, input logic b9,
                                      input logic stp);
        if (md == 2'b00) return 1'b1;
        if (md == 2'b01) return stp && (!mp || addr_hit(b, na, m));
        if (mp)          return b9 && addr_hit(b, na, m);
        return stp;
    endfunction

    task automatic drive_bit(input logic v, input bit glitch);
        if (glitch) begin
            rxd = v;  repeat (16) @(negedge clk);
            rxd = ~v; repeat (2)  @(negedge clk);
            rxd = v;  repeat (BIT_CLKS - 18) @(negedge clk);
        end else begin
            rxd = v;  repeat (BIT_CLKS) @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input logic b9,
                              input logic stp, input int glitch_idx);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(b[i], glitch_idx == i);
        if (frame_mode[1]) drive_bit(b9, 1'b0);
        drive_bit(stp, 1'b0);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
    endtask

    task automatic clear_flags();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        @(negedge clk);
        chk("R13", "rx_done after clear", rx_done, 0);
        chk("R13", "frame_err after clear", frame_err, 0);
    endtask

    task automatic run_case(input string tag, input logic [7:0] b, input logic b9,
                            input logic stp, input int glitch_idx);
        bit acc;
        logic eb9;
        acc = exp_accept(frame_mode, mp_en, node_addr, addr_mask, b, b9, stp);
        eb9 = frame_mode[1] ? b9 : stp;
        send_frame(b, b9, stp, glitch_idx);
        chk(tag, "rx_done", rx_done, acc);
        chk("R11", "frame_err", frame_err, !stp);
        if (acc) begin
            prev_byte = b;
            prev_b9   = eb9;
        end
        chk(acc ? tag : "R12", "rx_byte", rx_byte, prev_byte);
        chk(acc ? "R4" : "R12", "rx_bit9", rx_bit9, prev_b9);
        clear_flags();
    endtask

    task automatic setup(input logic [1:0] md, input logic mp,
                         input logic [7:0] na, input logic [7:0] m);
        frame_mode = md;
        mp_en      = mp;
        node_addr  = na;
        addr_mask  = m;
        @(negedge clk);
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rx_done reset", rx_done, 0);
        chk("R1", "frame_err reset", frame_err, 0);
        chk("R1", "rx_byte reset", rx_byte, 0);
        chk("R1", "rx_bit9 reset", rx_bit9, 0);

        // R2: a short low pulse is a false start.
        rxd = 1'b0; repeat (4) @(negedge clk);
        rxd = 1'b1; repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R2", "rx_done after false start", rx_done, 0);
        chk("R2", "rx_byte after false start", rx_byte, 0);

        // R5: plain mode accepts with bad stop and filter armed.
        setup(2'b00, 1'b1, 8'hA5, 8'hFF);
        run_case("R5", 8'h3C, 1'b0, 1'b0, -1);
        // R3: single-sample glitch on bits 0 and 5.
        setup(2'b01, 1'b0, 8'h00, 8'h00);
        run_case("R3", 8'hB2, 1'b0, 1'b1, 0);
        run_case("R3", 8'h4D, 1'b0, 1'b1, 5);
        // R8 / R9: node C0, mask 03, broadcast C3.
        setup(2'b01, 1'b1, 8'hC0, 8'h03);
        run_case("R8", 8'h3C, 1'b0, 1'b1, -1);
        run_case("R9", 8'hC3, 1'b0, 1'b1, -1);
        run_case("R12", 8'h41, 1'b0, 1'b1, -1);
        run_case("R6", 8'h3C, 1'b0, 1'b0, -1);
        // R7: 9-bit filter needs the ninth bit.
        setup(2'b10, 1'b1, 8'hC0, 8'h03);
        run_case("R7", 8'h3C, 1'b0, 1'b1, -1);
        run_case("R7", 8'h3C, 1'b1, 1'b1, -1);
        setup(2'b11, 1'b0, 8'hC0, 8'h03);
        run_case("R7", 8'h41, 1'b0, 1'b1, -1);
        // R10: zero node and mask let everything through.
        setup(2'b11, 1'b1, 8'h00, 8'h00);
        run_case("R10", 8'h5A, 1'b1, 1'b1, -1);
        setup(2'b01, 1'b1, 8'h00, 8'h00);
        run_case("R10", 8'hE7, 1'b0, 1'b1, -1);

        for (int k = 0; k < 30; k++) begin
            logic [7:0] na, m, b, r;
            logic [1:0] md;
            int sel;
            md  = 2'($urandom());
            na  = 8'($urandom());
            m   = ($urandom() % 4 == 0) ? 8'h00 : 8'($urandom());
            r   = 8'($urandom());
            sel = int'($urandom() % 3);
            if (sel == 0)      b = (na & m) | (r & ~m);
            else if (sel == 1) b = r | na | m;
            else               b = r;
            setup(md, 1'($urandom()), na, m);
            run_case(md == 2'b00 ? "R5" : (md == 2'b01 ? "R6" : "R7"),
                     b, 1'($urandom()), ($urandom() % 5) != 0, -1);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(negedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule